// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block sits between a converter sequencer and a register read port. Each finished conversion arrives as a 12-bit magnitude, a sign bit, the 3-bit number of the sequencer step that produced it, and a flag that marks a reduced-resolution (8 bits plus sign) result. The block keeps these fields in raw form in a 32-entry first-in first-out store. A read strobe removes the oldest entry and presents it as one 16-bit word.

The word is built when it is read, not when it is stored. The sign sits in bit 12. The result fills bits 11..0, or bits 11..4 with a fixed filler in bits 3..0 for reduced-resolution results. A configuration input selects what goes in the top three bits: the step number, or three copies of the sign so that the word reads as a two's complement value. The block also reports the number of unread entries as a 5-bit count and a sticky overflow flag.

The write side is a valid/ready stream. `wr_ready` is high whenever a slot is free. A beat offered while `wr_ready` is low is not held for later: it is discarded and raises `overflow`. The producer may therefore use `wr_ready` as back-pressure, or ignore it and watch `overflow`. The read side is a plain one-cycle strobe taken from the bus decode.

Top module: `tagged_result_fifo`

## Requirements
- R1: `wr_ready` is low exactly when 32 entries are held. A beat with `wr_valid` high and `wr_ready` high is stored at that clock edge.
- R2: Read strobes return stored entries in the order they were written.
- R3: Bit 12 of `rd_word` is the sign of the entry (0 positive, 1 negative). For a full-resolution entry (`wr_short`=0), bits 11..0 equal the written magnitude.
- R4: For a reduced-resolution entry (`wr_short`=1), bits 11..4 equal `wr_mag[7:0]` and bits 3..0 read 4'b1110.
- R5: When `cfg_tag_mode`=1, bits 15..13 carry the written step number. When it is 0, they carry three copies of the sign bit.
- R6: `cfg_tag_mode` is applied at read time. Changing it changes bits 15..13 of the word currently shown and of every entry still buffered.
- R7: `unread_cnt` equals the number of stored entries, saturating at 31 when 32 are held. A cycle with both an accepted write and a non-empty read leaves the count unchanged.
- R8: A beat offered while full is dropped: it never appears on the read side. It sets `overflow`, which stays high until a reset.
- R9: A read strobe while empty leaves `rd_word` and `unread_cnt` unchanged.
- R10: `dev_reset` held for one clock empties the store, clears `overflow`, and sets `rd_word` to 16'h0000 from the next cycle.
- R11: After `rst_n` reset: `unread_cnt`=0, `wr_ready`=1, `overflow`=0, `rd_word`=16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_reset | input | 1 | Synchronous device reset, empties the store |
| cfg_tag_mode | input | 1 | 1: top bits carry step number; 0: sign extension |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Space available |
| wr_mag | input | 12 | Result magnitude (bits 7..0 used when short) |
| wr_neg | input | 1 | Result sign, 1 = negative |
| wr_tag | input | 3 | Sequencer step number |
| wr_short | input | 1 | Reduced-resolution result |
| rd_strobe | input | 1 | Pop the oldest entry |
| rd_word | output | 16 | Formatted word of the last popped entry |
| unread_cnt | output | 5 | Unread entries, saturating at 31 |
| overflow | output | 1 | Sticky: a write was dropped |

## Verification
A corrupted read or write pointer shows up on the read after the next strobe: `rd_word` then holds a result out of order or a stale one, and the scoreboard reports the mismatch at that read. A wrong occupancy shows up in `unread_cnt` or `wr_ready` in the cycle after the write or read that caused it. A wrong fill point is found when the store is filled to 32 and one more beat is offered. Formatting faults are seen as soon as the affected entry is read, including when only `cfg_tag_mode` changes between reads.

// File: rtl/tfifo_pkg.sv
`timescale 1ns/1ps
package tfifo_pkg;
  localparam int MAG_W   = 12;
  localparam int TAG_W   = 3;
  localparam int SHORT_W = 8;
  localparam int FILL_W  = MAG_W - SHORT_W;
  localparam int WORD_W  = TAG_W + 1 + MAG_W;
  localparam logic [FILL_W-1:0] SHORT_FILL = 4'b1110;

  typedef struct packed {
    logic             short_res;
    logic [TAG_W-1:0] tag;
    logic             neg;
    logic [MAG_W-1:0] mag;
  } tf_entry_t;

  localparam int ENTRY_W = $bits(tf_entry_t);
endpackage

// File: rtl/tfifo_store.sv
`timescale 1ns/1ps
module tfifo_store
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      push,
  input  tf_entry_t wr_entry,
  input  logic      pop,
  output tf_entry_t rd_entry,
  output logic [OW-1:0] occ,
  output logic      full,
  output logic      empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [OW-1:0] OCC_MAX = OW'(DEPTH);

  tf_entry_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (occ == OCC_MAX);
  assign empty   = (occ == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rd_entry = mem[rptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/tfifo_hold.sv
`timescale 1ns/1ps
module tfifo_hold
  import tfifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      load,
  input  tf_entry_t d,
  output tf_entry_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/tfifo_fmt.sv
`timescale 1ns/1ps
module tfifo_fmt
  import tfifo_pkg::*;
(
  input  tf_entry_t          ent,
  input  logic               tag_mode,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word[MAG_W] = ent.neg;
    word[WORD_W-1:MAG_W+1] = tag_mode ? ent.tag : {TAG_W{ent.neg}};
    if (ent.short_res) begin
      word[MAG_W-1:FILL_W] = ent.mag[SHORT_W-1:0];
      word[FILL_W-1:0]     = SHORT_FILL;
    end else begin
      word[MAG_W-1:0] = ent.mag;
    end
  end
endmodule

// File: rtl/tagged_result_fifo.sv
`timescale 1ns/1ps
module tagged_result_fifo
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 5,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_reset,
  input  logic              cfg_tag_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [MAG_W-1:0]  wr_mag,
  input  logic              wr_neg,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_short,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  unread_cnt,
  output logic              overflow
);
  localparam logic [OW-1:0] CNT_CAP = OW'((1 << CNT_W) - 1);

  tf_entry_t in_ent, head_ent, held_ent;
  logic [OW-1:0] occ;
  logic full, empty, pop_ok;

  assign in_ent = '{short_res: wr_short, tag: wr_tag, neg: wr_neg, mag: wr_mag};
  assign pop_ok = rd_strobe && !empty && !dev_reset;

  tfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(dev_reset),
    .push(wr_valid), .wr_entry(in_ent),
    .pop(rd_strobe), .rd_entry(head_ent),
    .occ(occ), .full(full), .empty(empty)
  );

  tfifo_hold u_hold (
    .clk(clk), .rst_n(rst_n), .clr(dev_reset),
    .load(pop_ok), .d(head_ent), .q(held_ent)
  );

  tfifo_fmt u_fmt (
    .ent(held_ent), .tag_mode(cfg_tag_mode), .word(rd_word)
  );

  assign wr_ready   = !full;
  assign unread_cnt = (occ > CNT_CAP) ? CNT_CAP[CNT_W-1:0] : occ[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                overflow <= 1'b0;
    else if (dev_reset)        overflow <= 1'b0;
    else if (wr_valid && full) overflow <= 1'b1;
  end
endmodule

// File: rtl/tagged_result_fifo_chk.sv
`timescale 1ns/1ps
module tagged_result_fifo_chk
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_reset,
  input logic              cfg_tag_mode,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_strobe,
  input logic [WORD_W-1:0] rd_word,
  input logic              overflow,
  input logic [OW-1:0]     occ,
  input tf_entry_t         held_ent
);
  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tag_mode |-> rd_word[WORD_W-1:MAG_W+1] == {TAG_W{rd_word[MAG_W]}});

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !dev_reset) |=> overflow);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !dev_reset) |=> overflow);

  assert_full_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(DEPTH)) |-> !wr_ready);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_reset |=> (occ == $past(occ)) || (occ == OW'($past(occ) + 1'b1))
                   || (occ == OW'($past(occ) - 1'b1)));

  assert_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_strobe && occ != '0 && !dev_reset) |=> $stable(occ));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && occ == '0 && !wr_valid && !dev_reset) |=> (occ == '0) && $stable(held_ent));

  assert_dev_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> (occ == '0) && !overflow && (held_ent == '0));
endmodule

bind tagged_result_fifo tagged_result_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .cfg_tag_mode(cfg_tag_mode),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_strobe(rd_strobe),
  .rd_word(rd_word), .overflow(overflow), .occ(occ), .held_ent(held_ent)
);

// File: tb/sim_tagged_result_fifo.sv
`timescale 1ns/1ps
module sim_tagged_result_fifo;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, dev_reset, cfg_tag_mode, wr_valid, wr_ready, wr_neg, wr_short, rd_strobe, overflow;
  logic [11:0] wr_mag;
  logic [2:0]  wr_tag;
  logic [15:0] rd_word;
  logic [4:0]  unread_cnt;

  tagged_result_fifo u0 (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .cfg_tag_mode(cfg_tag_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_mag(wr_mag), .wr_neg(wr_neg),
    .wr_tag(wr_tag), .wr_short(wr_short), .rd_strobe(rd_strobe),
    .rd_word(rd_word), .unread_cnt(unread_cnt), .overflow(overflow)
  );

  int total = 0;
  int bad = 0;
  logic [16:0] sb [$];        // {short, tag, neg, mag}
  logic [16:0] last_raw = '0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [16:0] e, input logic mode);
    logic sh, ng;
    logic [2:0] tg;
    logic [11:0] mg, body;
    sh = e[16]; tg = e[15:13]; ng = e[12]; mg = e[11:0];
    body = sh ? {mg[7:0], 4'b1110} : mg;
    return {mode ? tg : {3{ng}}, ng, body};
  endfunction

  function automatic logic [4:0] exp_cnt();
    return (sb.size() > 31) ? 5'd31 : 5'(sb.size());
  endfunction

  // driver: offers one beat, pushes it to the scoreboard when accepted
  task automatic do_write(input logic [11:0] m, input logic n, input logic [2:0] t, input logic s);
    @(negedge clk);
    wr_valid = 1'b1; wr_mag = m; wr_neg = n; wr_tag = t; wr_short = s;
    if (wr_ready) sb.push_back({s, t, n, m});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // monitor: pops the expected item and compares the word after the edge
  task automatic do_read(input string req);
    @(negedge clk);
    rd_strobe = 1'b1;
    if (sb.size() > 0) last_raw = sb.pop_front();
    @(negedge clk);
    rd_strobe = 1'b0;
    check(req, "rd_word", 32'(rd_word), 32'(exp_word(last_raw, cfg_tag_mode)));
  endtask

  initial begin
    rst_n = 1'b0; dev_reset = 1'b0; cfg_tag_mode = 1'b1; wr_valid = 1'b0;
    wr_mag = '0; wr_neg = 1'b0; wr_tag = '0; wr_short = 1'b0; rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11", "unread_cnt", 32'(unread_cnt), 0);
    check("R11", "wr_ready", 32'(wr_ready), 1);
    check("R11", "overflow", 32'(overflow), 0);
    check("R11", "rd_word", 32'(rd_word), 0);

    // R9 read while empty
    do_read("R9");
    check("R9", "unread_cnt empty", 32'(unread_cnt), 0);

    // mixed entries: R3 full-resolution, R4 short, R5 tag field
    do_write(12'hABC, 1'b0, 3'd1, 1'b0);
    do_write(12'h5A7, 1'b1, 3'd2, 1'b0);
    do_write(12'h03C, 1'b0, 3'd6, 1'b1);
    do_write(12'hF81, 1'b1, 3'd7, 1'b1);
    check("R7", "count after 4 writes", 32'(unread_cnt), 32'(exp_cnt()));
    do_read("R3");
    do_read("R3");
    do_read("R4");
    cfg_tag_mode = 1'b0;
    do_read("R5");
    check("R5", "sign copies", 32'(rd_word[15:13]), 32'h7);
    check("R7", "count after drain", 32'(unread_cnt), 0);

    // R9 empty read keeps last word
    do_read("R9");
    check("R9", "word kept", 32'(rd_word), 32'(exp_word(17'h1FF81, 1'b0)));

    // R6 mode applied at read time
    cfg_tag_mode = 1'b1;
    do_write(12'h123, 1'b1, 3'd5, 1'b0);
    do_write(12'h456, 1'b0, 3'd3, 1'b0);
    do_read("R6");
    check("R6", "tag shown", 32'(rd_word[15:13]), 5);
    @(negedge clk);
    cfg_tag_mode = 1'b0;
    #1;
    check("R6", "held word re-formatted", 32'(rd_word[15:13]), 7);
    cfg_tag_mode = 1'b1;

    // R7 simultaneous write and read
    do_write(12'h777, 1'b1, 3'd4, 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_mag = 12'h0AA; wr_neg = 1'b0; wr_tag = 3'd0; wr_short = 1'b1;
    rd_strobe = 1'b1;
    last_raw = sb.pop_front();
    sb.push_back({1'b1, 3'd0, 1'b0, 12'h0AA});
    @(negedge clk);
    wr_valid = 1'b0; rd_strobe = 1'b0;
    check("R7", "count on write+read", 32'(unread_cnt), 2);
    check("R2", "word on write+read", 32'(rd_word), 32'(exp_word(last_raw, 1'b1)));

    // R1 fill to full, R8 overflow drop
    for (int i = 0; i < DEPTH - 2; i++)
      do_write(12'(i * 37 + 5), i[0], 3'(i), i[1]);
    check("R1", "wr_ready at full", 32'(wr_ready), 0);
    check("R7", "saturated count", 32'(unread_cnt), 31);
    check("R8", "no overflow yet", 32'(overflow), 0);
    do_write(12'hDEA, 1'b1, 3'd2, 1'b0);
    check("R8", "overflow set", 32'(overflow), 1);
    check("R8", "size unchanged", 32'(sb.size()), DEPTH);
    for (int i = 0; i < DEPTH; i++) do_read("R2");
    check("R1", "wr_ready after drain", 32'(wr_ready), 1);
    check("R8", "overflow sticky", 32'(overflow), 1);
    do_read("R9");
    check("R9", "count still zero", 32'(unread_cnt), 0);

    // R10 device reset
    do_write(12'h111, 1'b0, 3'd1, 1'b0);
    do_write(12'h222, 1'b1, 3'd2, 1'b0);
    do_write(12'h333, 1'b0, 3'd3, 1'b0);
    do_read("R2");
    @(negedge clk);
    dev_reset = 1'b1;
    @(negedge clk);
    dev_reset = 1'b0;
    sb.delete();
    last_raw = '0;
    check("R10", "unread_cnt", 32'(unread_cnt), 0);
    check("R10", "overflow", 32'(overflow), 0);
    check("R10", "rd_word", 32'(rd_word), 0);
    do_write(12'h444, 1'b1, 3'd4, 1'b1);
    do_read("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule